// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. It waits for a start request, holds the converter in a timed acquire window so the external sampling capacitor can settle, and then runs a binary search. On each clock of the search it presents a trial code to an external capacitive DAC and reads one comparator decision back. When the least significant decision has been made, the finished code moves into a parallel output latch and a one-cycle completion pulse is raised.

A start request is accepted only on the rising edge of the condition "chip select high and convert-start high". Once accepted, the sequencer ignores every further request until the result has been latched. The acquire window length is derived from the clock frequency and a minimum settling time, both parameters. All state returns to idle on a synchronous reset.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle: `busy`, `done` and `acq_phase` are 0, `result` is 0 and `dac_code` is 0.
- R2: A conversion is accepted only at a clock edge where `chip_sel` and `conv_start` are both 1; either one alone leaves `busy` at 0.
- R3: Acceptance needs a rising edge of (`chip_sel` and `conv_start`); holding both at 1 yields exactly one conversion.
- R4: While `busy` is 1, start requests are ignored: the running conversion completes unchanged and no second conversion follows.
- R5: After acceptance, `acq_phase` is 1 for exactly ACQ_CYCLES clocks, ACQ_CYCLES = ceil(CLK_FREQ_HZ x ACQ_TIME_NS / 1e9) (100 at 50 MHz and 2000 ns); `dac_code` is 0 whenever the search is not running.
- R6: The approximation register is cleared at each acceptance: the first trial code is 12'h800 regardless of any earlier result.
- R7: Bits are decided from bit 11 down to bit 0, one per clock; each trial sets the bit under test, and `cmp_high` = 1 (DAC above input) clears it while 0 keeps it, so an input level v in 0..4095 yields `result` = v.
- R8: At the edge of the bit-0 decision `result` is loaded, `done` is 1 for exactly one clock and `busy` falls; `busy` lasts ACQ_CYCLES + 12 clocks.
- R9: `result` keeps its previous value throughout a conversion and changes only when `done` is raised.
- R10: A reset during a conversion abandons it: no `done` follows and the R1 state is restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Chip select, active high |
| conv_start | input | 1 | Convert-start strobe, active high |
| cmp_high | input | 1 | Comparator decision: 1 when DAC output exceeds the held input |
| dac_code | output | 12 | Trial code to the capacitive DAC (0 outside the search) |
| acq_phase | output | 1 | High during the acquire window |
| busy | output | 1 | High from accepted start until the result is latched |
| done | output | 1 | One-clock pulse when `result` is loaded |
| result | output | 12 | Output latch holding the last finished code |

## Verification
A stale or misaligned bit pointer shows up on `dac_code` at the very first clock of the search, where the trial code must be exactly 12'h800, and later as a wrong value in `result` on the `done` clock. A miscounting acquire timer shifts the fall of `acq_phase` and the length of `busy`, both measured to the clock. A broken lockout or edge detector produces an extra `done` or an unexpected `busy` within one acquire window after the first result, which the scoreboard flags as an unexpected completion.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } sar_state_e;

    function automatic int acq_cycles_for(input int clk_hz, input int settle_ns);
        longint prod;
        prod = longint'(clk_hz) * longint'(settle_ns);
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/sar_start_qual.sv
module sar_start_qual (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic conv_start,
    output logic start_evt
);

    logic req_d, req_q;

    always_comb begin
        req_d     = chip_sel & conv_start;
        start_evt = req_d & ~req_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CW = (ACQ_CYCLES < 2) ? 1 : $clog2(ACQ_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(ACQ_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = run && (cnt_q == LAST);
        if (clear) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         cmp_high,
    output logic [W-1:0] trial,
    output logic [W-1:0] next_code,
    output logic         last
);

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] code;
        logic [W-1:0] mask;
    } eng_t;

    eng_t cur_q, nxt_d;

    always_comb begin
        trial     = cur_q.code | cur_q.mask;
        next_code = cmp_high ? cur_q.code : trial;
        last      = cur_q.mask[0];
        nxt_d     = cur_q;
        if (load) begin
            nxt_d.code = '0;
            nxt_d.mask = TOP_BIT;
        end else if (step) begin
            nxt_d.code = next_code;
            nxt_d.mask = cur_q.mask >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int RES_BITS    = 12,
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int ACQ_TIME_NS = 2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chip_sel,
    input  logic                conv_start,
    input  logic                cmp_high,
    output logic [RES_BITS-1:0] dac_code,
    output logic                acq_phase,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result
);

    localparam int ACQ_RAW    = acq_cycles_for(CLK_FREQ_HZ, ACQ_TIME_NS);
    localparam int ACQ_CYCLES = (ACQ_RAW < 1) ? 1 : ACQ_RAW;

    typedef struct packed {
        sar_state_e          state;
        logic                done;
        logic [RES_BITS-1:0] result;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                start_evt;
    logic                accept;
    logic                acq_run;
    logic                acq_expired;
    logic                search;
    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] final_code;
    logic                last_bit;

    sar_start_qual u_qual (
        .clk        (clk),
        .rst        (rst),
        .chip_sel   (chip_sel),
        .conv_start (conv_start),
        .start_evt  (start_evt)
    );

    sar_acq_timer #(
        .ACQ_CYCLES (ACQ_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .run     (acq_run),
        .expired (acq_expired)
    );

    sar_bit_engine #(
        .W (RES_BITS)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (search),
        .cmp_high  (cmp_high),
        .trial     (trial),
        .next_code (final_code),
        .last      (last_bit)
    );

    always_comb begin
        accept  = start_evt && (ctl_q.state == ST_IDLE);
        acq_run = (ctl_q.state == ST_ACQ);
        search  = (ctl_q.state == ST_CONV);

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.state = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (acq_expired) begin
                    ctl_d.state = ST_CONV;
                end
            end
            ST_CONV: begin
                if (last_bit) begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.result = final_code;
                    ctl_d.done   = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, done: 1'b0, result: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dac_code  = search ? trial : '0;
    assign acq_phase = acq_run;
    assign busy      = (ctl_q.state != ST_IDLE);
    assign done      = ctl_q.done;
    assign result    = ctl_q.result;

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int RES_BITS    = 12,
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int ACQ_TIME_NS = 2000
) (
    input logic                clk,
    input logic                rst,
    input logic                chip_sel,
    input logic                conv_start,
    input logic [RES_BITS-1:0] dac_code,
    input logic                acq_phase,
    input logic                busy,
    input logic                done,
    input logic [RES_BITS-1:0] result
);

    localparam int ACQ_RAW    = sar_ctrl_pkg::acq_cycles_for(CLK_FREQ_HZ, ACQ_TIME_NS);
    localparam int ACQ_CYCLES = (ACQ_RAW < 1) ? 1 : ACQ_RAW;
    localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

    int acq_seen;

    always_ff @(posedge clk) begin
        if (rst || !acq_phase) begin
            acq_seen <= 0;
        end else begin
            acq_seen <= acq_seen + 1;
        end
    end

    // R2: busy only rises after both start inputs were high
    a_r2_start_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(chip_sel && conv_start));

    // R4: a running conversion only ends through completion
    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R5: acquire window length
    a_r5_acq_window: assert property (@(posedge clk) disable iff (rst)
        ($fell(acq_phase) && !$past(rst)) |-> (acq_seen == ACQ_CYCLES));

    // R5: DAC idle outside the search
    a_r5_dac_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy || acq_phase) |-> (dac_code == '0));

    // R6: first trial after the acquire window is the top bit alone
    a_r6_first_trial: assert property (@(posedge clk) disable iff (rst)
        ($fell(acq_phase) && !$past(rst)) |-> (dac_code == TOP_BIT));

    // R8: completion pulse is one clock wide and ends busy
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: latch moves only with done
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(result));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_BITS    (RES_BITS),
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .ACQ_TIME_NS (ACQ_TIME_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_sel   (chip_sel),
    .conv_start (conv_start),
    .dac_code   (dac_code),
    .acq_phase  (acq_phase),
    .busy       (busy),
    .done       (done),
    .result     (result)
);

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;

    localparam int ACQ_N  = 100;
    localparam int BUSY_N = ACQ_N + 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_sel = 1'b0;
    logic        conv_start = 1'b0;
    logic [11:0] vin = '0;
    logic        cmp_high;
    logic [11:0] dac_code;
    logic        acq_phase;
    logic        busy;
    logic        done;
    logic [11:0] result;

    int n_checks = 0;
    int n_errors = 0;
    int done_total = 0;
    logic [11:0] exp_q[$];

    always #10 clk = ~clk;

    assign cmp_high = (dac_code > vin);

    sar_conv_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .chip_sel   (chip_sel),
        .conv_start (conv_start),
        .cmp_high   (cmp_high),
        .dac_code   (dac_code),
        .acq_phase  (acq_phase),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    int          busy_cnt = 0;
    int          acq_cnt = 0;
    bit          prev_acq = 1'b0;
    bit          dac_bad = 1'b0;
    bit          hold_bad = 1'b0;
    logic [11:0] last_res = '0;

    always @(negedge clk) begin
        if (rst) begin
            busy_cnt = 0; acq_cnt = 0; prev_acq = 1'b0;
            dac_bad = 1'b0; hold_bad = 1'b0; last_res = '0;
        end else begin
            if (busy) busy_cnt++;
            if (acq_phase) acq_cnt++;
            if ((!busy || acq_phase) && dac_code != 12'h000) dac_bad = 1'b1;
            if (!done && result != last_res) hold_bad = 1'b1;
            if (prev_acq && !acq_phase) begin
                check(acq_cnt == ACQ_N, "R5 acquire length", acq_cnt, ACQ_N);
                check(dac_code == 12'h800, "R6 first trial", dac_code, 12'h800);
                acq_cnt = 0;
            end
            prev_acq = acq_phase;
            if (done) begin
                done_total++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", 1, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(result == e, "R7 result", result, e);
                end
                check(busy == 1'b0, "R8 busy falls with done", busy, 0);
                check(busy_cnt == BUSY_N, "R8 busy length", busy_cnt, BUSY_N);
                check(!dac_bad, "R5 dac zero outside search", dac_bad, 0);
                check(!hold_bad, "R9 result held during conversion", hold_bad, 0);
                busy_cnt = 0; dac_bad = 1'b0; hold_bad = 1'b0;
                last_res = result;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        chip_sel = 1'b1; conv_start = 1'b1;
        @(negedge clk);
        chip_sel = 1'b0; conv_start = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R8 conversion completes", exp_q.size(), 0);
    endtask

    task automatic run_conv(input logic [11:0] v);
        vin = v;
        exp_q.push_back(v);
        pulse_start();
        wait_drain();
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && acq_phase == 0, "R1 control outputs", {busy, done, acq_phase}, 0);
        check(result == 0 && dac_code == 0, "R1 data outputs", result, 0);

        // R2 single qualifiers do not start
        @(negedge clk); chip_sel = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0, "R2 chip select alone", busy, 0);
        chip_sel = 1'b0; conv_start = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0, "R2 convert-start alone", busy, 0);
        conv_start = 1'b0;
        @(negedge clk);

        // R7 several input levels, R6 cleared register each time
        run_conv(12'hAAA);
        run_conv(12'h555);
        run_conv(12'h000);
        run_conv(12'hFFF);
        run_conv(12'h800);
        run_conv(12'h7FF);
        run_conv(12'h001);
        run_conv(12'h3C5);

        // R4 restart requests during acquire and search are ignored
        base = done_total;
        vin = 12'h9B2;
        exp_q.push_back(12'h9B2);
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (75) @(negedge clk);
        pulse_start();
        wait_drain();
        repeat (ACQ_N + 20) @(negedge clk);
        check(done_total - base == 1, "R4 single completion", done_total - base, 1);
        check(busy == 0, "R4 no queued restart", busy, 0);

        // R3 held qualifiers start one conversion only
        base = done_total;
        vin = 12'h234;
        exp_q.push_back(12'h234);
        @(negedge clk);
        chip_sel = 1'b1; conv_start = 1'b1;
        wait_drain();
        repeat (ACQ_N + 40) @(negedge clk);
        check(done_total - base == 1, "R3 one conversion while held", done_total - base, 1);
        check(busy == 0, "R3 idle while held", busy, 0);
        chip_sel = 1'b0; conv_start = 1'b0;
        @(negedge clk);

        // R10 reset mid-conversion
        base = done_total;
        vin = 12'hC3C;
        pulse_start();
        repeat (ACQ_N + 5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && acq_phase == 0 && done == 0, "R10 control after reset", busy, 0);
        check(result == 0 && dac_code == 0, "R10 data after reset", result, 0);
        repeat (40) @(negedge clk);
        check(done_total == base, "R10 no completion after abort", done_total - base, 0);

        // R6 register cleared after an abort and a prior result
        run_conv(12'h0F0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule